// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Register Bank

This block is a receive-only slave on a two-wire serial bus that holds the configuration of a clock distribution unit. A bus master addresses it with one fixed 7-bit address in write mode. The block then takes a stream of data bytes with no command or offset byte. The first data byte after the address lands in register 0, the next in register 1, and so on. Each register drives decoded output fields: output enables for several clock groups, a spread-spectrum enable and one frequency-select bit that exists only in the register bank.

The bus lines are oversampled by the system clock. START and STOP conditions and SCL edges are detected from the sampled lines. The block acknowledges by asserting an open-drain pull-down on SDA. The enable polarity differs between registers: registers 0 to 2 use 1 for enable, register 3 uses 0 for enable. Each register has its own reset value. Read transfers, clock stretching and arbitration are not supported.

Top module: `cfg_i2c_regbank`

## Requirements
- R1: After reset the outputs show the default configuration: mem_aux_en_o=1, usb_en_o=2'b11, spread_en_o=0, fsel_o=0, mem_en_o=8'hFF, bus_en_o=7'h7F, periph_en_o=8'hFF.
- R2: The address byte 8'hD2 (address 7'b1101001, R/W bit 0 in bit 0) is acknowledged. sda_oe_o pulls SDA low during the ninth SCL pulse of that byte.
- R3: Any other address byte, including the read form 8'hD3, is not acknowledged. The data bytes that follow are neither acknowledged nor stored until the next START.
- R4: Data bytes are shifted in MSB first. Each data byte is acknowledged. Consecutive data bytes fill registers 0, 1, 2, 3 in that order.
- R5: Register 0 field positions: bit 0 is mem_aux_en_o, bits 2:1 are usb_en_o[1:0], bit 3 is spread_en_o, bit 4 is fsel_o. Bits 7:5 are reserved. A 1 in a field bit enables that function.
- R6: Register 1 bit i drives mem_en_o[i]. Register 2 bits 7:1 drive bus_en_o[6:0], and bit 0 is reserved. Register 3 has inverted polarity: periph_en_o[i] equals the inverse of register 3 bit i.
- R7: Data bytes after the fourth byte of a transfer are acknowledged and do not change any output.
- R8: Every START, including a repeated START without a STOP, returns the write pointer to register 0.
- R9: A STOP releases SDA and ends the transfer. Bytes clocked after a STOP and before any START are not acknowledged and change nothing.
- R10: A data byte cut short by a STOP before its eighth bit is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 = pull SDA low (acknowledge) |
| mem_aux_en_o | output | 1 | Auxiliary memory clock enable |
| usb_en_o | output | 2 | 48 MHz group enables |
| spread_en_o | output | 1 | Spread-spectrum enable |
| fsel_o | output | 1 | Register-only frequency-select bit |
| mem_en_o | output | 8 | Memory clock enables |
| bus_en_o | output | 7 | Bus clock enables |
| periph_en_o | output | 8 | Peripheral clock enables (decoded from inverted register) |

## Verification
The hardest case to reach from the ports is a repeated START in the middle of a write. SDA must be released while SCL is low, then pulled low while SCL is high, with no STOP between the two. This START must send the pointer back to register 0 while keeping the registers already written. The bench drives this by calling its START task straight after a data byte. It then writes one byte and checks that only register 0 changed. A STOP that cuts a byte after three bits, and bytes clocked after a STOP, are driven in the same way with the line-level tasks. The bench then observes that the register outputs stay unchanged.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 4;
    localparam logic [6:0] DEV_ADDR = 7'b1101001;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_ADDR_ACK,
        RX_DATA,
        RX_DATA_ACK,
        RX_IGNORE
    } rx_state_e;

    function automatic logic [BYTE_W-1:0] reg_reset(input int idx);
        case (idx)
            0:       return 8'h07;
            1:       return 8'hFF;
            2:       return 8'hFE;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] reg_mask(input int idx);
        case (idx)
            0:       return 8'h1F;
            1:       return 8'hFF;
            2:       return 8'hFE;
            3:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/cfgbank_line_sync.sv
module cfgbank_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_bit_o
);
    typedef struct packed {
        logic scl_m;
        logic scl_s;
        logic scl_p;
        logic sda_m;
        logic sda_s;
        logic sda_p;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.scl_m = scl_i;
        s_d.scl_s = s_q.scl_m;
        s_d.scl_p = s_q.scl_s;
        s_d.sda_m = sda_i;
        s_d.sda_s = s_q.sda_m;
        s_d.sda_p = s_q.sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_rise_o = s_q.scl_s & ~s_q.scl_p;
    assign scl_fall_o = ~s_q.scl_s & s_q.scl_p;
    assign start_o    = s_q.scl_s & s_q.scl_p & s_q.sda_p & ~s_q.sda_s;
    assign stop_o     = s_q.scl_s & s_q.scl_p & ~s_q.sda_p & s_q.sda_s;
    assign sda_bit_o  = s_q.sda_s;
endmodule

// File: rtl/cfgbank_rx.sv
module cfgbank_rx
    import cfgbank_pkg::*;
#(
    parameter int NREG  = NUM_REGS,
    parameter int PTR_W = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_bit_i,
    output logic              ack_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_idx_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NREG);

    typedef struct packed {
        rx_state_e         state;
        logic [2:0]        cnt;
        logic              full;
        logic [BYTE_W-1:0] shift;
        logic              ack;
        logic              wr;
        logic [PTR_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
        logic [PTR_W-1:0]  ptr;
    } rx_t;

    rx_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.wr = 1'b0;
        if (start_i) begin
            r_d.state = RX_ADDR;
            r_d.cnt   = '0;
            r_d.full  = 1'b0;
            r_d.ack   = 1'b0;
            r_d.ptr   = '0;
        end else if (stop_i) begin
            r_d.state = RX_IDLE;
            r_d.full  = 1'b0;
            r_d.ack   = 1'b0;
        end else begin
            case (r_q.state)
                RX_ADDR, RX_DATA: begin
                    if (scl_rise_i && !r_q.full) begin
                        r_d.shift = {r_q.shift[BYTE_W-2:0], sda_bit_i};
                        r_d.cnt   = r_q.cnt + 3'd1;
                        r_d.full  = (r_q.cnt == 3'd7);
                    end else if (scl_fall_i && r_q.full) begin
                        r_d.full = 1'b0;
                        if (r_q.state == RX_ADDR) begin
                            if (r_q.shift == {DEV_ADDR, 1'b0}) begin
                                r_d.ack   = 1'b1;
                                r_d.state = RX_ADDR_ACK;
                            end else begin
                                r_d.state = RX_IGNORE;
                            end
                        end else begin
                            r_d.ack   = 1'b1;
                            r_d.wr    = 1'b1;
                            r_d.idx   = r_q.ptr;
                            r_d.data  = r_q.shift;
                            r_d.state = RX_DATA_ACK;
                            if (r_q.ptr != PTR_END) r_d.ptr = r_q.ptr + 1'b1;
                        end
                    end
                end
                RX_ADDR_ACK, RX_DATA_ACK: begin
                    if (scl_fall_i) begin
                        r_d.ack   = 1'b0;
                        r_d.cnt   = '0;
                        r_d.state = RX_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= RX_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_o     = r_q.ack;
    assign wr_en_o   = r_q.wr;
    assign wr_idx_o  = r_q.idx;
    assign wr_data_o = r_q.data;

    // R2: the acknowledge is only switched on at an SCL falling edge
    a_r2_ack_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ack) |-> $past(scl_fall_i));
    // R3: an ignored transfer never pulls SDA
    a_r3_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == RX_IGNORE) |-> !r_q.ack);
    // R4: every stored byte is acknowledged
    a_r4_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.wr |-> r_q.ack);
    // R7: the pointer saturates at the end of the bank
    a_r7_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ptr <= PTR_END);
    // R8: a START rewinds the pointer
    a_r8_start_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (r_q.ptr == '0) && (r_q.state == RX_ADDR));
    // R9: a STOP releases the line and idles
    a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !r_q.ack && (r_q.state == RX_IDLE));
endmodule

// File: rtl/cfgbank_regs.sv
module cfgbank_regs
    import cfgbank_pkg::*;
#(
    parameter int NREG  = NUM_REGS,
    parameter int PTR_W = $clog2(NREG + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [PTR_W-1:0]       wr_idx_i,
    input  logic [BYTE_W-1:0]      wr_data_i,
    output logic [NREG*BYTE_W-1:0] regs_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [BYTE_W-1:0] RST_VAL  = reg_reset(g);
        localparam logic [BYTE_W-1:0] WR_MASK  = reg_mask(g);
        localparam logic [PTR_W-1:0]  MY_INDEX = PTR_W'(g);

        logic [BYTE_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (wr_en_i && (wr_idx_i == MY_INDEX)) val_d = wr_data_i & WR_MASK;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= RST_VAL;
            else        val_q <= val_d;
        end

        assign regs_o[g*BYTE_W +: BYTE_W] = val_q;
    end

    // R7: a write at or beyond the end of the bank leaves every register alone
    a_r7_drop_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_idx_i >= PTR_W'(NREG))) |=> $stable(regs_o));
endmodule

// File: rtl/cfg_i2c_regbank.sv
module cfg_i2c_regbank
    import cfgbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic       mem_aux_en_o,
    output logic [1:0] usb_en_o,
    output logic       spread_en_o,
    output logic       fsel_o,
    output logic [7:0] mem_en_o,
    output logic [6:0] bus_en_o,
    output logic [7:0] periph_en_o
);
    localparam int PTR_W = $clog2(NUM_REGS + 1);

    logic scl_rise, scl_fall, start_det, stop_det, sda_bit;
    logic wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [NUM_REGS*BYTE_W-1:0] regs;

    cfgbank_line_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det),
        .sda_bit_o  (sda_bit)
    );

    cfgbank_rx #(.NREG(NUM_REGS), .PTR_W(PTR_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .sda_bit_i  (sda_bit),
        .ack_o      (sda_oe_o),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data)
    );

    cfgbank_regs #(.NREG(NUM_REGS), .PTR_W(PTR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .regs_o    (regs)
    );

    assign mem_aux_en_o = regs[0];
    assign usb_en_o     = regs[2:1];
    assign spread_en_o  = regs[3];
    assign fsel_o       = regs[4];
    assign mem_en_o     = regs[15:8];
    assign bus_en_o     = regs[23:17];
    assign periph_en_o  = ~regs[31:24];

    // R9: SDA is never pulled while the sampled bus shows a STOP
    a_r9_no_ack_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);
endmodule

// File: tb/cfg_i2c_regbank_test.sv
`timescale 1ns/1ps
module cfg_i2c_regbank_test;
    localparam int Q = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic mem_aux_en, spread_en, fsel;
    logic [1:0] usb_en;
    logic [7:0] mem_en, periph_en;
    logic [6:0] bus_en;
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    cfg_i2c_regbank uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .mem_aux_en_o (mem_aux_en),
        .usb_en_o     (usb_en),
        .spread_en_o  (spread_en),
        .fsel_o       (fsel),
        .mem_en_o     (mem_en),
        .bus_en_o     (bus_en),
        .periph_en_o  (periph_en)
    );

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic outs_check(string req, logic [31:0] exp_a, logic [31:0] exp_b);
        check(req, {8'h0, 3'b0, fsel, spread_en, usb_en, mem_aux_en, mem_en, 1'b0, bus_en}, exp_a);
        check(req, {24'h0, periph_en}, exp_b);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_bit(logic b);
        sda_m = b; wait_q();
        scl_m = 1'b1; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        acked = (sda_line == 1'b0);
        scl_m = 1'b0; wait_q();
    endtask

    task automatic t_reset();
        // R1: defaults {fsel,spread,usb,aux}=0_0_11_1, mem=FF, bus=7F, periph=FF
        outs_check("R1", {8'h0, 8'h07, 8'hFF, 8'h7F}, 32'hFF);
        check("R1 sda idle", {31'b0, sda_oe}, 32'h0);
    endtask

    task automatic t_addr_ack();
        logic a;
        i2c_start();
        send_byte(8'hD2, a);
        check("R2 address ack", {31'b0, a}, 32'h1);
        i2c_stop();
        check("R9 released after stop", {31'b0, sda_oe}, 32'h0);
    endtask

    task automatic t_wrong_addr();
        logic a;
        i2c_start();
        send_byte(8'hA4, a);
        check("R3 foreign address nack", {31'b0, a}, 32'h0);
        send_byte(8'h00, a);
        check("R3 data after foreign address nack", {31'b0, a}, 32'h0);
        send_byte(8'h00, a);
        i2c_stop();
        i2c_start();
        send_byte(8'hD3, a);
        check("R3 read address nack", {31'b0, a}, 32'h0);
        send_byte(8'h00, a);
        i2c_stop();
        outs_check("R3 unchanged", {8'h0, 8'h07, 8'hFF, 8'h7F}, 32'hFF);
    endtask

    task automatic t_sequential();
        logic a;
        int acks = 0;
        i2c_start();
        send_byte(8'hD2, a);
        send_byte(8'h18, a); acks += int'(a);
        send_byte(8'hA5, a); acks += int'(a);
        send_byte(8'h54, a); acks += int'(a);
        send_byte(8'h3C, a); acks += int'(a);
        i2c_stop();
        check("R4 all data bytes acked", acks, 4);
        // R5: 0x18 -> fsel=1 spread=1 usb=00 aux=0; R6: bus=0x54>>1, periph=~0x3C
        outs_check("R5 R6 fields", {8'h0, 8'h18, 8'hA5, 8'h2A}, 32'hC3);
    endtask

    task automatic t_overflow();
        logic a;
        int acks = 0;
        i2c_start();
        send_byte(8'hD2, a);
        send_byte(8'h0B, a);
        send_byte(8'h01, a);
        send_byte(8'h80, a);
        send_byte(8'hFF, a);
        send_byte(8'h00, a); acks += int'(a);
        send_byte(8'hFF, a); acks += int'(a);
        send_byte(8'h00, a); acks += int'(a);
        i2c_stop();
        check("R7 extra bytes acked", acks, 3);
        // 0x0B -> spread=1 usb=01 aux=1; periph=~FF=00
        outs_check("R7 extra bytes dropped", {8'h0, 8'h0B, 8'h01, 8'h40}, 32'h00);
    endtask

    task automatic t_restart();
        logic a;
        i2c_start();
        send_byte(8'hD2, a);
        send_byte(8'h10, a);
        send_byte(8'h7E, a);
        i2c_start();
        send_byte(8'hD2, a);
        check("R8 address after repeated start", {31'b0, a}, 32'h1);
        send_byte(8'h01, a);
        i2c_stop();
        outs_check("R8 pointer rewound", {8'h0, 8'h01, 8'h7E, 8'h40}, 32'h00);
    endtask

    task automatic t_stop_partial();
        logic a;
        i2c_start();
        send_byte(8'hD2, a);
        send_byte(8'h08, a);
        send_bit(1'b0);
        send_bit(1'b0);
        send_bit(1'b0);
        i2c_stop();
        outs_check("R10 partial byte dropped", {8'h0, 8'h08, 8'h7E, 8'h40}, 32'h00);
        send_byte(8'hD2, a);
        check("R9 no ack after stop", {31'b0, a}, 32'h0);
        send_byte(8'hFF, a);
        send_byte(8'h00, a);
        outs_check("R9 bytes after stop ignored", {8'h0, 8'h08, 8'h7E, 8'h40}, 32'h00);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_addr_ack();
        t_wrong_addr();
        t_sequential();
        t_overflow();
        t_restart();
        t_stop_partial();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule